// File: doc/BRIEF.md
# Streaming Accelerator Dataflow Controller

This block sits between three parties: an input stream link that offers 32-bit words, a processing core with a clock-enable and start handshake, and an output stream link that accepts results. It decides in every cycle whether a word moves from the input link into the core, whether a finished result moves from the core to the output link, or both at once. It freezes the core through its clock enable whenever the core is holding a result that the output link cannot take yet. This way no result is overwritten and no input word is taken that the core cannot process.

Control is a single five-phase state machine. The phases are idle, read-only, write-only, combined read-write and stall. Transfer enables are combinational from the current phase and the live handshakes, so a transfer completes in the same cycle its conditions are met. Each transfer lasts exactly one cycle per word. Data passes through unchanged in both directions.

Top module: `stream_flow_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset with `in_rdy` low, `core_ce`, `core_start`, `in_rd`, `core_we` and `out_wr` are all 0.
- R2: Out of reset the controller waits in its idle phase. There `core_ce` and `core_start` follow `in_rdy`, and no transfer happens (`in_rd` = `out_wr` = 0). A cycle with `in_rdy` high moves it to the read phase, and it never returns to idle.
- R3: Outside idle, when `in_rdy`, `core_rfd` are 1, `core_done` is 0 and no stall is present, `in_rd` and `core_we` are 1 in that same cycle, and `core_din` equals `in_data`.
- R4: A high `core_done` or a low `core_rfd` blocks reading. `in_rd` stays 0 and no input word is consumed, even while `in_rdy` is 1.
- R5: Outside idle, `out_wr` is 1 exactly in cycles where `core_dv` and `out_rdy` are both 1. `out_data` then equals `core_dout`.
- R6: When `core_dv` is 1 and `out_rdy` is 0 (stall), `core_ce`, `core_start`, `in_rd` and `out_wr` are all 0, and the next phase is stall.
- R7: In the cycle that `out_rdy` returns high during a stall, `core_ce` and `core_start` return to 1 and the held result is written.
- R8: When both a read and a write are allowed in the same cycle, both happen in that cycle, and the next phase is the combined read-write phase.
- R9: Under random gaps on both links, the output stream equals the input stream after the core's transformation, in order, with no word duplicated or lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_rdy | input | 1 | Input link has a word available |
| in_data | input | 32 | Word offered by the input link |
| in_rd | output | 1 | One-cycle pulse: consume the offered word |
| core_ce | output | 1 | Core clock enable |
| core_start | output | 1 | Core start, same timing as `core_ce` |
| core_rfd | input | 1 | Core can accept an input word |
| core_done | input | 1 | Core has finished and must not take more input |
| core_dv | input | 1 | Core result valid |
| core_din | output | 32 | Word passed to the core |
| core_we | output | 1 | Core input strobe, one cycle per word |
| core_dout | input | 32 | Core result word |
| out_rdy | input | 1 | Output link can accept a word |
| out_data | output | 32 | Word presented to the output link |
| out_wr | output | 1 | One-cycle pulse: output link takes the word |

## Verification
The embedded assertions check on every cycle the rules that follow from the live inputs. Reads only happen under the read conditions, writes only with a valid result and a ready link, the core is frozen while a result is blocked, the phase after a blocked result is stall, the clock enable is restored when a stall clears, and no transfer occurs in idle. Ordering and the absence of duplicated or lost words (R9) cannot be seen in one cycle. Only the bench shows them, by running a fixed-latency core model against a scoreboard under random link gaps. The same holds for the idle wake-up sequence and for the actual overlap of read and write in one cycle.

// File: rtl/sfc_pkg.sv
// Shared types for the streaming dataflow controller.
// Assumes: nothing beyond IEEE 1800-2017.
package sfc_pkg;

    // Controller phase; idle is only used between reset and the first input.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_READ  = 3'd1,
        PH_STALL = 3'd2,
        PH_WRITE = 3'd3,
        PH_RDWR  = 3'd4
    } phase_e;

    // Per-cycle decision produced by the condition classifier.
    typedef struct packed {
        logic rd;      // consume one input word into the core
        logic wr;      // move one core result to the output link
        logic freeze;  // core holds a result the output cannot take
        logic run;     // core clock enable / start level
    } xfer_t;

endpackage

// File: rtl/sfc_cond.sv
// Classifies the live handshakes into one transfer decision per cycle.
// Assumes: all inputs are stable before the clock edge; purely combinational.
module sfc_cond
    import sfc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e phase,
    input  logic   in_rdy,
    input  logic   core_rfd,
    input  logic   core_done,
    input  logic   core_dv,
    input  logic   out_rdy,
    output xfer_t  xfer
);

    logic is_idle;
    logic blocked;
    logic can_read;
    logic can_write;

    // Idle decode and stall condition.
    always_comb begin
        is_idle = (phase == PH_IDLE);
        blocked = core_dv && !out_rdy;
    end

    // Read and write qualification, independent of each other.
    always_comb begin
        can_read  = !is_idle && !blocked && in_rdy && core_rfd && !core_done;
        can_write = !is_idle && core_dv && out_rdy;
    end

    // Pack the decision; the core runs unless blocked, or waits for input in idle.
    always_comb begin
        xfer.rd     = can_read;
        xfer.wr     = can_write;
        xfer.freeze = !is_idle && blocked;
        xfer.run    = is_idle ? in_rdy : !blocked;
    end

    // R4
    rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer.rd |-> (in_rdy && core_rfd && !core_done));

    // R5
    wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer.wr |-> (core_dv && out_rdy));

endmodule

// File: rtl/sfc_phase.sv
// Phase register and next-phase logic of the controller.
// Assumes: xfer comes from sfc_cond for the same cycle; synchronous active-low reset.
module sfc_phase
    import sfc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   in_rdy,
    input  logic   core_dv,
    input  logic   out_rdy,
    input  xfer_t  xfer,
    output phase_e phase
);

    phase_e phase_q;
    phase_e phase_d;

    // Next phase from the decision taken this cycle.
    always_comb begin
        phase_d = phase_q;
        if (phase_q == PH_IDLE) begin
            phase_d = in_rdy ? PH_READ : PH_IDLE;
        end else if (xfer.freeze) begin
            phase_d = PH_STALL;
        end else if (xfer.rd && xfer.wr) begin
            phase_d = PH_RDWR;
        end else if (xfer.wr) begin
            phase_d = PH_WRITE;
        end else begin
            phase_d = PH_READ;
        end
    end

    // Phase register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    assign phase = phase_q;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (phase_q == PH_IDLE));

    // R2
    no_return_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE) |=> (phase_q != PH_IDLE));

    // R6
    stall_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE && core_dv && !out_rdy) |=> (phase_q == PH_STALL));

    // R8
    rdwr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer.rd && xfer.wr) |=> (phase_q == PH_RDWR));

endmodule

// File: rtl/sfc_steer.sv
// Drives link enables, core handshake and the pass-through data paths.
// Assumes: decisions are single-cycle, so each enable is a one-cycle pulse per word.
module sfc_steer
    import sfc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        phase,
    input  xfer_t         xfer,
    input  logic [DW-1:0] in_data,
    input  logic [DW-1:0] core_dout,
    output logic          in_rd,
    output logic          core_we,
    output logic [DW-1:0] core_din,
    output logic          core_ce,
    output logic          core_start,
    output logic [DW-1:0] out_data,
    output logic          out_wr
);

    // Input side: consume and strobe into the core together.
    always_comb begin
        in_rd    = xfer.rd;
        core_we  = xfer.rd;
        core_din = in_data;
    end

    // Output side: result passes unchanged.
    always_comb begin
        out_wr   = xfer.wr;
        out_data = core_dout;
    end

    // Core handshake: enable and start share one level.
    always_comb begin
        core_ce    = rst_n && xfer.run;
        core_start = rst_n && xfer.run;
    end

    // R6
    stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer.freeze |-> (!core_ce && !core_start && !in_rd && !out_wr));

    // R7
    resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STALL && out_rdy_seen(xfer)) |-> (core_ce && core_start));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> (!in_rd && !out_wr));

    function automatic logic out_rdy_seen(input xfer_t x);
        return !x.freeze;
    endfunction

endmodule

// File: rtl/stream_flow_ctrl.sv
// Top of the streaming dataflow controller: classifier, phase register, steering.
// Assumes: the core advances only while core_ce is high and keeps core_dv/core_dout
// stable while frozen; both links use a ready/enable pulse handshake.
module stream_flow_ctrl
    import sfc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_rdy,
    input  logic [DW-1:0] in_data,
    output logic          in_rd,
    output logic          core_ce,
    output logic          core_start,
    input  logic          core_rfd,
    input  logic          core_done,
    input  logic          core_dv,
    output logic [DW-1:0] core_din,
    output logic          core_we,
    input  logic [DW-1:0] core_dout,
    input  logic          out_rdy,
    output logic [DW-1:0] out_data,
    output logic          out_wr
);

    phase_e phase;
    xfer_t  xfer;

    sfc_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .in_rdy    (in_rdy),
        .core_rfd  (core_rfd),
        .core_done (core_done),
        .core_dv   (core_dv),
        .out_rdy   (out_rdy),
        .xfer      (xfer)
    );

    sfc_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_rdy  (in_rdy),
        .core_dv (core_dv),
        .out_rdy (out_rdy),
        .xfer    (xfer),
        .phase   (phase)
    );

    sfc_steer #(.DW(DW)) u_steer (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .xfer       (xfer),
        .in_data    (in_data),
        .core_dout  (core_dout),
        .in_rd      (in_rd),
        .core_we    (core_we),
        .core_din   (core_din),
        .core_ce    (core_ce),
        .core_start (core_start),
        .out_data   (out_data),
        .out_wr     (out_wr)
    );

    // R5
    out_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr |-> (out_data == core_dout));

    // R3
    in_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_rd |-> (core_we && core_din == in_data));

endmodule

// File: tb/tb_stream_flow_ctrl.sv
// Scoreboard bench: a core model with fixed latency, random link gaps.
module tb_stream_flow_ctrl;

    localparam int DW  = 32;
    localparam int LAT = 3;
    localparam logic [DW-1:0] KADD = 32'h1111_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_rdy = 1'b0;
    logic [DW-1:0] in_data;
    logic          in_rd;
    logic          core_ce, core_start;
    logic          core_rfd = 1'b1;
    logic          core_done = 1'b0;
    logic          core_dv;
    logic [DW-1:0] core_din;
    logic          core_we;
    logic [DW-1:0] core_dout;
    logic          out_rdy = 1'b1;
    logic [DW-1:0] out_data;
    logic          out_wr;

    logic [DW-1:0] src_word = 32'h0000_0101;
    logic [DW-1:0] pd [LAT];
    logic          pv [LAT];
    logic [DW-1:0] exp_q [$];
    int checks = 0;
    int fails  = 0;
    int n_rd = 0;
    int n_wr = 0;
    int overlap = 0;
    bit done_flag = 0;
    logic [DW-1:0] held;

    always #5 clk = ~clk;

    assign in_data   = src_word;
    assign core_dv   = pv[LAT-1];
    assign core_dout = pd[LAT-1];

    stream_flow_ctrl #(.DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .in_rdy(in_rdy), .in_data(in_data), .in_rd(in_rd),
        .core_ce(core_ce), .core_start(core_start), .core_rfd(core_rfd),
        .core_done(core_done), .core_dv(core_dv), .core_din(core_din),
        .core_we(core_we), .core_dout(core_dout), .out_rdy(out_rdy),
        .out_data(out_data), .out_wr(out_wr)
    );

    // Core model: pipeline advances only on core_ce; adds KADD to each word.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin pv[i] <= 1'b0; pd[i] <= '0; end
        end else if (core_ce) begin
            pv[0] <= core_we;
            pd[0] <= core_din + KADD;
            for (int i = 1; i < LAT; i++) begin pv[i] <= pv[i-1]; pd[i] <= pd[i-1]; end
        end
    end

    // Input source advances after each consumed word.
    always @(posedge clk) begin
        if (in_rd) src_word <= src_word + 32'h0103_0017;
    end

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver side of the scoreboard: every consumed word yields an expected result.
    always @(negedge clk) begin
        #2;
        if (rst_n && in_rd) begin
            exp_q.push_back(in_data + KADD);
            n_rd++;
        end
    end

    // Monitor side: every written word must match the oldest expectation (R9).
    always @(negedge clk) begin
        #2;
        if (rst_n && out_wr) begin
            n_wr++;
            if (in_rd) overlap++;
            if (exp_q.size() == 0) chk(0, "R9 write without input", out_data, '0);
            else chk(out_data == exp_q[0], "R9 order", out_data, exp_q[0]);
            if (exp_q.size() != 0) void'(exp_q.pop_front());
        end
    end

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done_flag) begin
            done_flag = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(10 * 150000);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        int ov0;
        int q0;
        // R1: reset levels
        repeat (3) tick();
        #1;
        chk(!core_ce && !core_start && !in_rd && !core_we && !out_wr, "R1 reset",
            {core_ce, core_start, in_rd, core_we, out_wr}, '0);
        tick(); rst_n = 1'b1;
        #1;
        chk(!core_ce && !core_start && !in_rd && !out_wr, "R1 first cycle",
            {core_ce, core_start, in_rd, out_wr}, '0);
        // R2: idle waits without input
        repeat (2) begin
            tick(); #1;
            chk(!core_ce && !in_rd, "R2 idle wait", {core_ce, in_rd}, '0);
        end
        // R2: wake cycle, no read yet
        tick(); in_rdy = 1'b1; #1;
        chk(core_ce && core_start && !in_rd, "R2 wake", {core_ce, core_start, in_rd}, 3'b110);
        // R3: read in the following cycle
        tick(); #1;
        chk(in_rd && core_we && core_din == in_data, "R3 read", core_din, in_data);
        // R4: core not ready for data blocks reading
        tick(); core_rfd = 1'b0; #1;
        q0 = n_rd;
        chk(!in_rd, "R4 rfd low", {31'd0, in_rd}, '0);
        tick(); core_rfd = 1'b1; core_done = 1'b1; #1;
        chk(!in_rd && n_rd == q0, "R4 done high", {31'd0, in_rd}, '0);
        tick(); core_done = 1'b0; in_rdy = 1'b0;
        repeat (LAT + 3) tick();
        chk(exp_q.size() == 0, "R5 drain", exp_q.size(), '0);
        // R6/R7: one word, output blocked
        out_rdy = 1'b0; in_rdy = 1'b1; #1;
        chk(in_rd, "R3 read before stall", {31'd0, in_rd}, 1);
        tick(); in_rdy = 1'b0;
        repeat (LAT + 1) tick();
        #1;
        held = out_data;
        chk(core_dv && !core_ce && !core_start && !out_wr && !in_rd, "R6 freeze",
            {core_dv, core_ce, core_start, out_wr, in_rd}, 5'b10000);
        tick(); in_rdy = 1'b1; #1;
        chk(!in_rd && !core_ce && out_data == held, "R6 held", out_data, held);
        tick(); in_rdy = 1'b0; out_rdy = 1'b1; #1;
        chk(core_ce && core_start && out_wr && out_data == held, "R7 resume", out_data, held);
        repeat (LAT + 3) tick();
        // R8: continuous flow overlaps read and write
        ov0 = overlap;
        in_rdy = 1'b1; out_rdy = 1'b1;
        repeat (20) tick();
        in_rdy = 1'b0;
        chk(overlap - ov0 >= 10, "R8 overlap", overlap - ov0, 10);
        repeat (LAT + 3) tick();
        // R9: random gaps on both links
        for (int c = 0; c < 3000; c++) begin
            tick();
            in_rdy   = ($urandom_range(0, 9) < 7);
            out_rdy  = ($urandom_range(0, 9) < 6);
            core_rfd = ($urandom_range(0, 9) != 0);
        end
        tick(); in_rdy = 1'b0; out_rdy = 1'b1; core_rfd = 1'b1;
        repeat (LAT + 4) tick();
        chk(exp_q.size() == 0 && n_rd == n_wr, "R9 no loss", n_wr, n_rd);
        chk(n_rd > 500, "R9 traffic", n_rd, 500);
        finish_run();
    end

endmodule